// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

This block turns a signed two's-complement vector (X, Y) through an angle supplied alongside it. A new vector and angle may be presented on every clock. A fold stage first brings the angle into the half-plane where the iteration converges. A chain of circular-mode micro-rotation stages then drives the residual angle toward zero, adding or subtracting arithmetically shifted copies of X and Y. A short cascade of shift-and-add factors then removes the rotation gain of about 1.6468 without a multiplier, and the result is clipped back to the data width.

The angle is an 8-bit two's-complement code `a` meaning `a·π/128` radians, so the code range covers −π to just under +π. Internal X and Y carry two guard bits. A companion strobe travels alongside the data, so the output strobe rises a fixed number of cycles after the input strobe. The block has no control state beyond these valid flags.

Top module: `cordic_rotator`

## Requirements
- R1: With the default 8 micro-rotation stages, `out_valid` rises exactly 14 cycles after the cycle in which `in_valid` was high. That is 1 fold stage, 8 micro stages and 5 gain stages. One vector is accepted every clock and results leave in input order.
- R2: The angle input is an 8-bit two's-complement code `a` for the angle θ = a·π/128. The output approximates (x·cosθ − y·sinθ, x·sinθ + y·cosθ), within a few LSB plus about a tenth of the vector length.
- R3: When `a` > 64 or `a` < −64, the fold stage negates X and Y and moves the angle by π (it flips the angle's top bit). Code −128 is therefore a half turn. After folding, the angle always lies within ±64.
- R4: Micro stage i uses direction d = +1 when the residual angle is ≥ 0 and d = −1 otherwise. It forms X − d·(Y>>>i), Y + d·(X>>>i) and Z − d·round(atan(2^−i)·128/π). After the last stage the residual lies within ±2 codes.
- R5: X and Y are held with two guard bits (10 bits). No stage wraps for any 8-bit input, including (−128, −128), and intermediate magnitudes stay within 320.
- R6: The gain is removed by multiplying by 1.25, 31/32, 257/256 and 1023/1024 and then halving. Each step uses shifts and one add or subtract, and the cascade preserves the sign of each coordinate.
- R7: A result outside −128..127 is clipped to the nearer limit, −128 or 127.
- R8: A synchronous active-high `rst` clears every valid flag. `out_valid` stays low during reset, and vectors in flight when reset is applied never appear at the output.
- R9: A zero input vector yields exactly (0, 0) for any angle.
- R10: A cycle with `in_valid` low yields no output strobe, so gaps in the input stream reappear unchanged at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid flags |
| in_valid | input | 1 | Input vector and angle are valid |
| in_x | input | 8 | Input X, two's complement |
| in_y | input | 8 | Input Y, two's complement |
| in_ang | input | 8 | Rotation angle code, a·π/128 |
| out_valid | output | 1 | Result is valid |
| out_x | output | 8 | Rotated, gain-corrected, clipped X |
| out_y | output | 8 | Rotated, gain-corrected, clipped Y |

## Verification
The quadrant fold and the output clipping can both act on the same vector. A full-scale vector such as (127, 127) with a code beyond ±64 is negated by the fold and still grows past the output range, so clipping follows. The bench sends such vectors back to back with unfolded and exact-boundary angles (±64, 65). It judges each result against an ideal rotation computed with real arithmetic and clipped to −128..127, so a wrong fold sign, a wrapped guard bit or a missing clip all show up as large deviations.

// File: rtl/cordic_rot_pkg.sv
package cordic_rot_pkg;

    // Deepest micro-rotation chain the angle table supports
    localparam int MAX_STAGES = 13;

    // atan(2^-idx) in units of 2*pi/65536, rounded
    function automatic int atan_q16(input int idx);
        case (idx)
            0:       return 8192;
            1:       return 4836;
            2:       return 2555;
            3:       return 1297;
            4:       return 651;
            5:       return 326;
            6:       return 163;
            7:       return 81;
            8:       return 41;
            9:       return 20;
            10:      return 10;
            11:      return 5;
            12:      return 3;
            default: return 0;
        endcase
    endfunction

    // Same angle rescaled to an ang_w-bit full-turn code, rounded to nearest
    function automatic int atan_code(input int idx, input int ang_w);
        int drop;
        drop = 16 - ang_w;
        return ((atan_q16(idx) * 2) / (2 ** drop) + 1) / 2;
    endfunction

endpackage

// File: rtl/cordic_fold.sv
module cordic_fold #(
    parameter int DW = 8,
    parameter int IW = 10,
    parameter int AW = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_v,
    input  logic [DW-1:0]        i_x,
    input  logic [DW-1:0]        i_y,
    input  logic [AW-1:0]        i_a,
    output logic                 o_v,
    output logic signed [IW-1:0] o_x,
    output logic signed [IW-1:0] o_y,
    output logic signed [AW-1:0] o_a
);
    localparam int QTR = 2 ** (AW - 2);

    logic signed [IW-1:0] x_ext, y_ext;
    logic                 flip;
    int                   a_int;

    always_comb begin
        x_ext = {{(IW-DW){i_x[DW-1]}}, i_x};
        y_ext = {{(IW-DW){i_y[DW-1]}}, i_y};
        a_int = int'($signed(i_a));
        flip  = (a_int > QTR) || (a_int < -QTR);
    end

    always_ff @(posedge clk) begin
        if (rst) o_v <= 1'b0;
        else     o_v <= i_v;
    end

    // Half-turn move: negate the vector and flip the angle sign bit
    always_ff @(posedge clk) begin
        if (flip) begin
            o_x <= -x_ext;
            o_y <= -y_ext;
            o_a <= {~i_a[AW-1], i_a[AW-2:0]};
        end else begin
            o_x <= x_ext;
            o_y <= y_ext;
            o_a <= i_a;
        end
    end

    AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (rst)
        o_v |-> (int'(o_a) <= QTR && int'(o_a) >= -QTR)); // R3

endmodule

// File: rtl/cordic_micro_stage.sv
module cordic_micro_stage
    import cordic_rot_pkg::*;
#(
    parameter int DW    = 8,
    parameter int IW    = 10,
    parameter int AW    = 8,
    parameter int SHIFT = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_v,
    input  logic signed [IW-1:0] i_x,
    input  logic signed [IW-1:0] i_y,
    input  logic signed [AW-1:0] i_z,
    output logic                 o_v,
    output logic signed [IW-1:0] o_x,
    output logic signed [IW-1:0] o_y,
    output logic signed [AW-1:0] o_z
);
    localparam logic signed [AW-1:0] STEP  = AW'(atan_code(SHIFT, AW));
    localparam int                   BOUND = (5 * (2 ** (DW - 1))) / 2;

    logic                 dir_pos;
    logic signed [IW-1:0] x_sh, y_sh, x_nx, y_nx;
    logic signed [AW-1:0] z_nx;

    always_comb begin
        dir_pos = ~i_z[AW-1];
        x_sh    = i_x >>> SHIFT;
        y_sh    = i_y >>> SHIFT;
        if (dir_pos) begin
            x_nx = i_x - y_sh;
            y_nx = i_y + x_sh;
            z_nx = i_z - STEP;
        end else begin
            x_nx = i_x + y_sh;
            y_nx = i_y - x_sh;
            z_nx = i_z + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) o_v <= 1'b0;
        else     o_v <= i_v;
    end

    always_ff @(posedge clk) begin
        o_x <= x_nx;
        o_y <= y_nx;
        o_z <= z_nx;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        o_v |-> (int'(o_x) <= BOUND && int'(o_x) >= -BOUND &&
                 int'(o_y) <= BOUND && int'(o_y) >= -BOUND)); // R5

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (rst)
        (i_v && i_x == '0 && i_y == '0) |=> (o_x == '0 && o_y == '0)); // R9

endmodule

// File: rtl/cordic_gain_comp.sv
module cordic_gain_comp #(
    parameter int DW = 8,
    parameter int IW = 10
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 i_v,
    input  logic signed [IW-1:0] i_x,
    input  logic signed [IW-1:0] i_y,
    output logic                 o_v,
    output logic [DW-1:0]        o_x,
    output logic [DW-1:0]        o_y
);
    localparam int                   NFAC = 4;
    localparam logic signed [IW-1:0] MAXV = IW'(2 ** (DW - 1) - 1);
    localparam logic signed [IW-1:0] MINV = -IW'(2 ** (DW - 1));

    logic                 cv [NFAC+1];
    logic signed [IW-1:0] cx [NFAC+1];
    logic signed [IW-1:0] cy [NFAC+1];

    assign cv[0] = i_v;
    assign cx[0] = i_x;
    assign cy[0] = i_y;

    // Factors 1+1/4, 1-1/32, 1+1/256, 1-1/1024: one add or subtract each
    for (genvar k = 0; k < NFAC; k++) begin : g_fac
        localparam int SH  = (k == 0) ? 2 : (k == 1) ? 5 : (k == 2) ? 8 : 10;
        localparam bit SUB = (k % 2) == 1;

        always_ff @(posedge clk) begin
            if (rst) cv[k+1] <= 1'b0;
            else     cv[k+1] <= cv[k];
        end

        if (SUB) begin : g_sub
            always_ff @(posedge clk) begin
                cx[k+1] <= cx[k] - (cx[k] >>> SH);
                cy[k+1] <= cy[k] - (cy[k] >>> SH);
            end
        end else begin : g_add
            always_ff @(posedge clk) begin
                cx[k+1] <= cx[k] + (cx[k] >>> SH);
                cy[k+1] <= cy[k] + (cy[k] >>> SH);
            end
        end
    end

    function automatic logic [DW-1:0] clip(input logic signed [IW-1:0] v);
        if (v > MAXV)      return MAXV[DW-1:0];
        else if (v < MINV) return MINV[DW-1:0];
        else               return v[DW-1:0];
    endfunction

    // Final halving and clip to the output width
    always_ff @(posedge clk) begin
        if (rst) o_v <= 1'b0;
        else     o_v <= cv[NFAC];
    end

    always_ff @(posedge clk) begin
        o_x <= clip(cx[NFAC] >>> 1);
        o_y <= clip(cy[NFAC] >>> 1);
    end

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (rst)
        o_v |-> (o_x[DW-1] == $past(cx[NFAC][IW-1]) &&
                 o_y[DW-1] == $past(cy[NFAC][IW-1]))); // R6

endmodule

// File: rtl/cordic_rotator.sv
module cordic_rotator
    import cordic_rot_pkg::*;
#(
    parameter int DW     = 8,
    parameter int AW     = 8,
    parameter int STAGES = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_x,
    input  logic [DW-1:0] in_y,
    input  logic [AW-1:0] in_ang,
    output logic          out_valid,
    output logic [DW-1:0] out_x,
    output logic [DW-1:0] out_y
);
    localparam int GUARD = 2;
    localparam int IW    = DW + GUARD;

    logic                 pv [STAGES+1];
    logic signed [IW-1:0] px [STAGES+1];
    logic signed [IW-1:0] py [STAGES+1];
    logic signed [AW-1:0] pz [STAGES+1];

    cordic_fold #(.DW(DW), .IW(IW), .AW(AW)) u_fold (
        .clk (clk),
        .rst (rst),
        .i_v (in_valid),
        .i_x (in_x),
        .i_y (in_y),
        .i_a (in_ang),
        .o_v (pv[0]),
        .o_x (px[0]),
        .o_y (py[0]),
        .o_a (pz[0])
    );

    for (genvar g = 0; g < STAGES; g++) begin : g_micro
        cordic_micro_stage #(.DW(DW), .IW(IW), .AW(AW), .SHIFT(g)) u_stage (
            .clk (clk),
            .rst (rst),
            .i_v (pv[g]),
            .i_x (px[g]),
            .i_y (py[g]),
            .i_z (pz[g]),
            .o_v (pv[g+1]),
            .o_x (px[g+1]),
            .o_y (py[g+1]),
            .o_z (pz[g+1])
        );
    end

    cordic_gain_comp #(.DW(DW), .IW(IW)) u_gain (
        .clk (clk),
        .rst (rst),
        .i_v (pv[STAGES]),
        .i_x (px[STAGES]),
        .i_y (py[STAGES]),
        .o_v (out_valid),
        .o_x (out_x),
        .o_y (out_y)
    );

    if (AW == 8 && STAGES >= 7 && STAGES <= MAX_STAGES) begin : g_res_chk
        AST_RESIDUAL_SMALL: assert property (@(posedge clk) disable iff (rst)
            pv[STAGES] |-> (int'(pz[STAGES]) <= 2 && int'(pz[STAGES]) >= -2)); // R4
    end

    AST_VALID_CLEARED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid); // R8

endmodule

// File: tb/sim_cordic_rotator.sv
module sim_cordic_rotator;
    localparam int CLK_NS = 10;
    localparam int LAT    = 14;
    localparam int NV     = 16;
    localparam int MAXQ   = 256;

    localparam int VEC [NV][3] = '{
        '{100, 0, 0},     '{100, 0, 32},    '{0, 100, 64},    '{100, 0, 64},
        '{60, -80, -40},  '{-90, 50, 96},   '{-90, 50, -96},  '{100, 20, -128},
        '{100, 20, 127},  '{127, 127, 32},  '{-128, -128, 32},'{-128, -128, 0},
        '{0, 0, 77},      '{50, 50, -64},   '{-70, -30, 65},  '{127, 127, 96}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_x = '0, in_y = '0, in_ang = '0;
    logic       out_valid;
    logic [7:0] out_x, out_y;

    cordic_rotator u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_y(in_y),
        .in_ang(in_ang), .out_valid(out_valid), .out_x(out_x), .out_y(out_y)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int    total = 0, bad = 0;
    int    tx_n = 0, rx_n = 0;
    int    ex [MAXQ], ey [MAXQ], tol [MAXQ], sent [MAXQ];
    string tg [MAXQ];

    task automatic check_int(input string req, input int act, input int expv, input int tl);
        total++;
        if (act > expv + tl || act < expv - tl) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (tol %0d)", req, act, expv, tl);
        end
    endtask

    function automatic int clip8(input real v);
        int r;
        r = int'(v);
        if (r > 127)  r = 127;
        if (r < -128) r = -128;
        return r;
    endfunction

    function automatic string vec_req(input int a, input int x, input int y);
        if (x == 0 && y == 0)    return "R9 zero vector";
        if (a > 64 || a < -64)   return "R3 folded angle";
        if ((x == 127 && y == 127) || (x == -128 && y == -128)) return "R7/R5 full scale";
        return "R2 rotation";
    endfunction

    // Ideal rotation by a*pi/128, clipped; tolerance scales with length (R2, R4, R6, R7)
    task automatic send(input int x, input int y, input int a);
        real th, mag;
        @(negedge clk);
        in_valid = 1'b1;
        in_x     = x[7:0];
        in_y     = y[7:0];
        in_ang   = a[7:0];
        th  = a * 3.14159265358979 / 128.0;
        mag = $sqrt(real'(x * x + y * y));
        ex[tx_n]   = clip8(x * $cos(th) - y * $sin(th));
        ey[tx_n]   = clip8(x * $sin(th) + y * $cos(th));
        tol[tx_n]  = (x == 0 && y == 0) ? 0 : 3 + int'(0.1 * mag);
        sent[tx_n] = cyc;
        tg[tx_n]   = vec_req(a, x, y);
        tx_n++;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (rx_n >= tx_n) begin
                total++;
                bad++;
                $display("FAIL R10 unexpected out_valid actual=1 expected=0");
            end else begin
                check_int("R1 latency", cyc, sent[rx_n] + LAT, 0);
                check_int({tg[rx_n], " x"}, int'($signed(out_x)), ex[rx_n], tol[rx_n]);
                check_int({tg[rx_n], " y"}, int'($signed(out_y)), ey[rx_n], tol[rx_n]);
                rx_n++;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int quiet;
        repeat (3) @(negedge clk);
        check_int("R8 valid low in reset", int'(out_valid), 0, 0);
        rst = 1'b0;

        // Table walked back to back, one vector per clock (R1, R2, R3, R7, R9)
        for (int i = 0; i < NV; i++) send(VEC[i][0], VEC[i][1], VEC[i][2]);
        idle(LAT + 4);
        check_int("R1 all results returned", rx_n, tx_n, 0);

        // Gaps in the stream are preserved (R10)
        for (int i = 0; i < 6; i++) begin
            send(VEC[i][0], VEC[i][1], VEC[i][2]);
            idle(1 + (i % 2));
        end
        idle(LAT + 4);
        check_int("R10 bubbled results returned", rx_n, tx_n, 0);

        // Reset with vectors in flight: none may emerge (R8)
        for (int i = 0; i < 4; i++) send(VEC[i + 4][0], VEC[i + 4][1], VEC[i + 4][2]);
        idle(3);
        @(negedge clk);
        rst  = 1'b1;
        rx_n = tx_n;
        @(negedge clk);
        rst = 1'b0;
        quiet = 0;
        for (int k = 0; k < LAT + 6; k++) begin
            @(negedge clk);
            if (out_valid) quiet++;
        end
        check_int("R8 flushed by reset", quiet, 0, 0);

        // Pipeline usable again after reset; exact-zero and fold boundary (R9, R3)
        send(0, 0, -128);
        send(-70, -30, 64);
        idle(LAT + 4);
        check_int("R8 recovery results returned", rx_n, tx_n, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule